// File: doc/BRIEF.md
# NAND Command/Data Phase Sequencer

This block accepts single-word accesses from a simple request port and turns each one into a sequence of strobes on an 8-bit NAND flash bus. The operation is not set up through registers. Every control field comes from the access address itself: the target chip, the phase, the opcodes, the number of address bytes and whether chip enable is dropped afterwards.

A command-phase access sends a start opcode with CLE. It then sends a programmed number of address bytes with ALE, taken from the write data word. It can finish with a second opcode. When the start opcode is the read-type opcode, the second opcode waits until the ready/busy line reports ready. A data-phase access moves one word of bytes: it writes them with WE# pulses or reads them with RE# pulses. It can append an end opcode and can release chip enable once it completes.

Each strobe is held low for a parameterised number of clock cycles and is followed by one recovery cycle. Chip enable stays on the selected device between accesses, so that a command phase and its data phases form one flash operation.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, every chip enable is high, WE# and RE# are high, CLE, ALE and the bus output enable are low, and `req_ready` is high.
- R2: When address bit 19 is 0 (command phase), the first bus cycle is a WE# pulse with CLE high that carries address bits [10:3] as the opcode.
- R3: In the command phase, address bits [23:21] give the number of address bytes (0 to 7). Each address byte is sent as a WE# pulse with ALE high. Byte i is write-data byte (i mod WORD_BYTES), least significant byte first.
- R4: When address bit 20 is 1, the access ends with a WE# pulse with CLE high that carries address bits [18:11]. This applies in both phases. When bit 20 is 0, no end opcode is sent.
- R5: In the command phase, when the start opcode equals READ_OPC (default 8'h00) and bit 20 is 1, the end opcode is not sent until `nand_rb` is 1. In every other case the end opcode follows the last address byte with no wait.
- R6: When address bit 19 is 1 (data phase), a write sends the WORD_BYTES bytes of write data, least significant first, on WE# pulses with CLE and ALE low. A read takes WORD_BYTES bytes on RE# pulses into `rsp_rdata`, first byte in the least significant position.
- R7: Every WE# or RE# low pulse lasts exactly WE_CYC clock cycles (WE_CYC ≥ 2). CLE and ALE are never high together. WE# and RE# are never low together. The output enable is low while RE# is low.
- R8: The low bits of address [31:24] select which chip enable goes low at acceptance. At most one chip enable is low at any time. The selection stays after the access unless the access is a data phase with address bit 21 set. In that case all chip enables go high one cycle after `rsp_valid`.
- R9: `req_ready` is high only when the sequencer is idle. `rsp_valid` is a one-cycle pulse at the end of every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_write | input | 1 | 1 = data-phase write, 0 = data-phase read |
| req_addr | input | 32 | Access address carrying the control fields |
| req_wdata | input | 8*WORD_BYTES | Address bytes or write data |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 8*WORD_BYTES | Bytes read in a data-phase read |
| nand_ce_n | output | CHIPS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Bus byte driven to the flash |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
Command phases are tried with a single address byte and no end opcode, then with five address bytes, which makes the byte index wrap past the word. One command phase with zero address bytes and a non-read start opcode is run while the flash reports busy. Comparing it with the read-type case, which is held busy for many cycles, shows whether the ready wait is applied to the right opcode only. Data-phase reads and writes on different chips show byte order and chip selection. Data phases with and without the release flag show whether chip enable is kept or dropped.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD1,
      ST_ADDR,
      ST_WAITRB,
      ST_CMD2,
      ST_DATA,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic [7:0] chip;
      logic [2:0] naddr;
      logic       clr_cs;
      logic       end_vld;
      logic       data_ph;
      logic [7:0] end_opc;
      logic [7:0] start_opc;
   } acc_fields_t;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
   import nand_seq_pkg::*;
(
   input  logic [31:0] addr,
   output acc_fields_t f
);
   localparam int CHIP_LSB  = 24;
   localparam int NADDR_LSB = 21;
   localparam int ENDV_BIT  = 20;
   localparam int PHASE_BIT = 19;
   localparam int ENDC_LSB  = 11;
   localparam int START_LSB = 3;

   logic unused_lsb;
   assign unused_lsb = ^addr[START_LSB-1:0];

   always_comb begin
      f.chip      = addr[CHIP_LSB +: 8];
      f.naddr     = addr[NADDR_LSB +: 3];
      f.clr_cs    = addr[NADDR_LSB];
      f.end_vld   = addr[ENDV_BIT];
      f.data_ph   = addr[PHASE_BIT];
      f.end_opc   = addr[ENDC_LSB +: 8];
      f.start_opc = addr[START_LSB +: 8];
   end
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
   parameter int PULSE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic low,
   output logic sample,
   output logic slot_end
);
   localparam int CW = $clog2(PULSE + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || slot_end)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign low      = run && (cnt < CW'(PULSE));
   assign sample   = run && (cnt == CW'(PULSE - 1));
   assign slot_end = run && (cnt == CW'(PULSE));
endmodule

// File: rtl/nand_seq_cesel.sv
module nand_seq_cesel #(
   parameter int CHIPS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [$clog2(CHIPS)-1:0] sel,
   input  logic                     release_i,
   output logic [CHIPS-1:0]         ce_n
);
   localparam int SW = $clog2(CHIPS);

   for (genvar i = 0; i < CHIPS; i++) begin : g_ce
      always_ff @(posedge clk) begin
         if (!rst_n)
            ce_n[i] <= 1'b1;
         else if (load)
            ce_n[i] <= (sel != SW'(i));
         else if (release_i)
            ce_n[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
   import nand_seq_pkg::*;
#(
   parameter int         CHIPS      = 4,
   parameter int         WE_CYC     = 3,
   parameter int         WORD_BYTES = 4,
   parameter logic [7:0] READ_OPC   = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [31:0]             req_addr,
   input  logic [8*WORD_BYTES-1:0] req_wdata,
   output logic                    rsp_valid,
   output logic [8*WORD_BYTES-1:0] rsp_rdata,
   output logic [CHIPS-1:0]        nand_ce_n,
   output logic                    nand_cle,
   output logic                    nand_ale,
   output logic                    nand_we_n,
   output logic                    nand_re_n,
   output logic [7:0]              nand_io_out,
   output logic                    nand_io_oe,
   input  logic [7:0]              nand_io_in,
   input  logic                    nand_rb
);
   localparam int DW     = 8 * WORD_BYTES;
   localparam int CHIP_W = $clog2(CHIPS);
   localparam int BI_W   = $clog2(WORD_BYTES);

   if (WE_CYC < 2) begin : g_bad_pulse
      $error("WE_CYC must be at least 2");
   end
   if (CHIPS < 2 || CHIPS > 16 || (1 << CHIP_W) != CHIPS) begin : g_bad_chips
      $error("CHIPS must be a power of two from 2 to 16");
   end
   if (WORD_BYTES < 2 || WORD_BYTES > 8 || (1 << BI_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be 2, 4 or 8");
   end

   seq_state_e  state, nxt;
   acc_fields_t dec, r_f;
   logic        r_write;
   logic [DW-1:0] r_wdata, r_rdata;
   logic [2:0]  bidx;
   logic        run, s_low, s_sample, s_end;
   logic        accept, is_rd_opc, drive_we;
   seq_state_e  after_addr, after_cmd1;
   logic        unused_bits;

   nand_seq_decode u_dec (.addr(req_addr), .f(dec));

   assign unused_bits = ^{r_f.chip, dec.chip[7:CHIP_W]};

   assign accept    = req_valid && (state == ST_IDLE);
   assign is_rd_opc = (r_f.start_opc == READ_OPC);
   assign run       = (state == ST_CMD1) || (state == ST_ADDR) ||
                      (state == ST_CMD2) || (state == ST_DATA);

   nand_seq_strobe #(.PULSE(WE_CYC)) u_strb (
      .clk(clk), .rst_n(rst_n), .run(run),
      .low(s_low), .sample(s_sample), .slot_end(s_end)
   );

   nand_seq_cesel #(.CHIPS(CHIPS)) u_ce (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .sel(dec.chip[CHIP_W-1:0]),
      .release_i((state == ST_DONE) && r_f.data_ph && r_f.clr_cs),
      .ce_n(nand_ce_n)
   );

   always_comb begin
      after_addr = !r_f.end_vld ? ST_DONE : (is_rd_opc ? ST_WAITRB : ST_CMD2);
      after_cmd1 = (r_f.naddr != 3'd0) ? ST_ADDR : after_addr;
      nxt = state;
      unique case (state)
         ST_IDLE:   if (req_valid) nxt = dec.data_ph ? ST_DATA : ST_CMD1;
         ST_CMD1:   if (s_end) nxt = after_cmd1;
         ST_ADDR:   if (s_end && bidx == r_f.naddr - 3'd1) nxt = after_addr;
         ST_WAITRB: if (nand_rb) nxt = ST_CMD2;
         ST_CMD2:   if (s_end) nxt = ST_DONE;
         ST_DATA:   if (s_end && bidx == 3'(WORD_BYTES - 1))
                       nxt = r_f.end_vld ? ST_CMD2 : ST_DONE;
         ST_DONE:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_f     <= '0;
         r_write <= 1'b0;
         r_wdata <= '0;
         r_rdata <= '0;
         bidx    <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            r_f     <= dec;
            r_write <= req_write;
            r_wdata <= req_wdata;
            r_rdata <= '0;
         end
         if (state != nxt)
            bidx <= '0;
         else if (s_end && (state == ST_ADDR || state == ST_DATA))
            bidx <= bidx + 3'd1;
         if (state == ST_DATA && !r_write && s_sample)
            r_rdata[{bidx[BI_W-1:0], 3'b000} +: 8] <= nand_io_in;
      end
   end

   assign drive_we = (state == ST_CMD1) || (state == ST_ADDR) ||
                     (state == ST_CMD2) || (state == ST_DATA && r_write);

   always_comb begin
      unique case (state)
         ST_CMD1: nand_io_out = r_f.start_opc;
         ST_CMD2: nand_io_out = r_f.end_opc;
         ST_ADDR, ST_DATA: nand_io_out = r_wdata[{bidx[BI_W-1:0], 3'b000} +: 8];
         default: nand_io_out = 8'h00;
      endcase
   end

   assign nand_cle   = (state == ST_CMD1) || (state == ST_CMD2);
   assign nand_ale   = (state == ST_ADDR);
   assign nand_we_n  = !(s_low && drive_we);
   assign nand_re_n  = !(s_low && state == ST_DATA && !r_write);
   assign nand_io_oe = drive_we;
   assign req_ready  = (state == ST_IDLE);
   assign rsp_valid  = (state == ST_DONE);
   assign rsp_rdata  = r_rdata;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
   parameter int CHIPS  = 4,
   parameter int WE_CYC = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [CHIPS-1:0] nand_ce_n,
   input logic             nand_cle,
   input logic             nand_ale,
   input logic             nand_we_n,
   input logic             nand_re_n,
   input logic             nand_io_oe
);
   localparam int LW = $clog2(WE_CYC + 2);

   logic [LW-1:0] we_low, re_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_low <= '0;
         re_low <= '0;
      end else begin
         we_low <= nand_we_n ? '0 : we_low + 1'b1;
         re_low <= nand_re_n ? '0 : re_low + 1'b1;
      end
   end

   assert_cle_ale_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));
   assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_io_oe);
   assert_we_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (we_low == LW'(WE_CYC)));
   assert_re_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_re_n) |-> (re_low == LW'(WE_CYC)));
   assert_ce_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));
   assert_ce_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> ($countones(~nand_ce_n) == 1));
   assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_rsp_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
endmodule

bind nand_seq_top nand_seq_chk #(.CHIPS(CHIPS), .WE_CYC(WE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
   .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe)
);

// File: tb/sim_nand_seq_top.sv
module sim_nand_seq_top;
   localparam int CHIPS  = 4;
   localparam int WE_CYC = 3;
   localparam int WB     = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]   req_addr = '0;
   logic [8*WB-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [8*WB-1:0] rsp_rdata;
   logic [CHIPS-1:0] nand_ce_n;
   logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
   logic [7:0]    nand_io_out;
   logic [7:0]    nand_io_in;
   logic          nand_rb = 1'b1;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   nand_seq_top #(.CHIPS(CHIPS), .WE_CYC(WE_CYC), .WORD_BYTES(WB)) u0 (.*);

   // bus model and monitor
   int         n_log = 0;
   int         log_t [64];
   logic [7:0] log_v [64];
   int         we_cnt = 0, rd_cnt = 0;
   logic       prev_we = 1'b1, prev_re = 1'b1;
   logic [31:0] last_rdata;

   assign nand_io_in = 8'hA0 + 8'(rd_cnt);

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!nand_we_n) we_cnt <= we_cnt + 1;
      if (nand_we_n && !prev_we) begin
         check(we_cnt == WE_CYC, "R7 we width", we_cnt, WE_CYC);
         if (n_log < 64) begin
            log_t[n_log] = nand_cle ? 0 : (nand_ale ? 1 : 2);
            log_v[n_log] = nand_io_out;
         end
         n_log <= n_log + 1;
         we_cnt <= 0;
      end
      if (nand_re_n && !prev_re) rd_cnt <= rd_cnt + 1;
      prev_we <= nand_we_n;
      prev_re <= nand_re_n;
   end

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic start_acc(input logic wr, input logic [31:0] a, input logic [31:0] d);
      while (!req_ready) @(negedge clk);
      n_log = 0;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (!rsp_valid) @(negedge clk);
      last_rdata = rsp_rdata;
      @(negedge clk);
      check(!rsp_valid, "R9 rsp one cycle", 32'(rsp_valid), 0);
   endtask

   task automatic chk_log(input int i, input int t, input logic [7:0] v, input string tag);
      check(log_t[i] == t && log_v[i] == v, tag, {log_t[i][7:0], log_v[i]}, {t[7:0], v});
   endtask

   function automatic logic [31:0] cmd_addr(input int chip, input int na, input logic ev,
                                            input logic [7:0] ec, input logic [7:0] sc);
      return (32'(chip) << 24) | (32'(na) << 21) | (32'(ev) << 20) |
             (32'(ec) << 11) | (32'(sc) << 3);
   endfunction

   function automatic logic [31:0] dat_addr(input int chip, input logic clr, input logic ev,
                                            input logic [7:0] ec);
      return (32'(chip) << 24) | (32'(clr) << 21) | (32'(ev) << 20) |
             (32'h1 << 19) | (32'(ec) << 11);
   endfunction

   task automatic t_reset_R1();
      check(nand_ce_n == '1, "R1 ce_n", nand_ce_n, 4'hF);
      check(nand_we_n && nand_re_n, "R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
      check(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches", {nand_cle, nand_ale, nand_io_oe}, 0);
      check(req_ready, "R1 ready", 32'(req_ready), 1);
   endtask

   task automatic t_cmd_short_R2();
      start_acc(1'b0, cmd_addr(0, 1, 1'b0, 8'h00, 8'h90), 32'h0000_0000);
      check(!req_ready, "R9 busy while running", 32'(req_ready), 0);
      wait_done();
      check(n_log == 2, "R4 no end opcode", n_log, 2);
      chk_log(0, 0, 8'h90, "R2 start opcode");
      chk_log(1, 1, 8'h00, "R3 single address");
      check(nand_ce_n == 4'b1110, "R8 chip0 kept", nand_ce_n, 4'b1110);
   endtask

   task automatic t_cmd_read_wait_R5();
      nand_rb = 1'b0;
      start_acc(1'b0, cmd_addr(0, 5, 1'b1, 8'h30, 8'h00), 32'h4433_2211);
      repeat (80) @(negedge clk);
      check(n_log == 6, "R5 held before ready", n_log, 6);
      check(nand_cle == 1'b0, "R5 no CLE while busy", 32'(nand_cle), 0);
      nand_rb = 1'b1;
      wait_done();
      check(n_log == 7, "R4 end sent", n_log, 7);
      chk_log(0, 0, 8'h00, "R2 read opcode");
      chk_log(1, 1, 8'h11, "R3 addr0");
      chk_log(2, 1, 8'h22, "R3 addr1");
      chk_log(3, 1, 8'h33, "R3 addr2");
      chk_log(4, 1, 8'h44, "R3 addr3");
      chk_log(5, 1, 8'h11, "R3 addr4 wraps");
      chk_log(6, 0, 8'h30, "R4 end opcode");
   endtask

   task automatic t_cmd_nowait_R5();
      nand_rb = 1'b0;
      start_acc(1'b0, cmd_addr(3, 0, 1'b1, 8'hD0, 8'h60), 32'hFFFF_FFFF);
      repeat (40) @(negedge clk);
      check(req_ready, "R5 non-read opcode not held", 32'(req_ready), 1);
      check(n_log == 2, "R3 zero address bytes", n_log, 2);
      chk_log(0, 0, 8'h60, "R2 start");
      chk_log(1, 0, 8'hD0, "R5 end immediately");
      check(nand_ce_n == 4'b0111, "R8 chip3 selected", nand_ce_n, 4'b0111);
      nand_rb = 1'b1;
   endtask

   task automatic t_data_read_R6();
      logic [31:0] exp;
      int base;
      base = rd_cnt;
      for (int i = 0; i < 4; i++) exp[i*8 +: 8] = 8'hA0 + 8'(base + i);
      start_acc(1'b0, dat_addr(1, 1'b0, 1'b0, 8'h00), 32'h0);
      wait_done();
      check(last_rdata == exp, "R6 read bytes", last_rdata, exp);
      check(n_log == 0, "R6 no WE on read", n_log, 0);
      check(nand_ce_n == 4'b1101, "R8 chip1 kept", nand_ce_n, 4'b1101);
   endtask

   task automatic t_data_write_clr_R8();
      start_acc(1'b1, dat_addr(2, 1'b1, 1'b1, 8'h10), 32'hDEAD_BEEF);
      check(nand_ce_n == 4'b1011, "R8 chip2 during access", nand_ce_n, 4'b1011);
      wait_done();
      check(n_log == 5, "R6 write count", n_log, 5);
      chk_log(0, 2, 8'hEF, "R6 wbyte0");
      chk_log(1, 2, 8'hBE, "R6 wbyte1");
      chk_log(2, 2, 8'hAD, "R6 wbyte2");
      chk_log(3, 2, 8'hDE, "R6 wbyte3");
      chk_log(4, 0, 8'h10, "R4 data end opcode");
      check(nand_ce_n == 4'b1111, "R8 ce released", nand_ce_n, 4'b1111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_R1();
      rst_n = 1'b1;
      @(negedge clk);
      t_cmd_short_R2();
      t_cmd_read_wait_R5();
      t_cmd_nowait_R5();
      t_data_read_R6();
      t_data_write_clr_R8();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      check(1'b0, "watchdog R9", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule